// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator

This block supplies the complex local-oscillator sample for a digital frequency shifter. It keeps a wide phase register and adds a programmable increment to it each time the advance strobe marks an accepted input sample. Because the phase only moves on that strobe, the oscillator stays in step with a streaming IQ input even when the stream has gaps. The upper bits of the phase index a sine table that is computed while the design elaborates. The block reads the table twice, once at a quarter-turn offset for cosine, and returns a registered cosine/sine pair in signed Q1.15.

Software picks the increment as round(f_shift / Fs * 2^P), where P is the phase width. The width can be set from 24 to 32 bits, and the frequency step is Fs / 2^P. At 2.4 MS/s that step is about 0.143 Hz for 24 bits and about 0.00056 Hz for 32 bits. To shift downward, load the two's complement of the increment.

Top module: `quad_nco`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `loValid` is 0 and both `loCos` and `loSin` are 0.
- R2: `loValid` is 1 exactly in the cycle after a cycle in which `advance` was 1, and 0 otherwise.
- R3: On each advance the phase becomes (phase + `phaseInc`) mod 2^PHASE_W. It does not change otherwise, so wrap-around returns it to the same angle.
- R4: Only the top LUT_AW bits of the phase (default 10) select the table entry, and the lower bits are dropped. With the default widths, an increment of 2^22-1 leaves the second output equal to the first.
- R5: The table entry for index k is round(32768*sin(2*pi*k/2^LUT_AW)), clamped to at most +32767. Cosine uses index k + 2^LUT_AW/4 (mod 2^LUT_AW). So cos(0)=32767, cos(pi)=-32768, sin(pi/2)=32767 and sin(3pi/2)=-32768.
- R6: The first output after reset is `loCos`=32767 and `loSin`=0, whatever `phaseInc` holds.
- R7: `loCos` and `loSin` hold their values through cycles with no advance.
- R8: A two's-complement (negative) increment turns the oscillator the other way. With increment -2^30, the sine sequence is 0, -32768, 0, 32767.
- R9: `phaseInc` is sampled on the advancing edge. The n-th output after reset uses the sum of the increments of the n-1 advances before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Marks an accepted input sample: emit an LO sample and step the phase |
| phaseInc | input | PHASE_W | Phase increment, two's complement |
| loValid | output | 1 | Output pair is fresh this cycle |
| loCos | output | DATA_W | Cosine, signed Q1.15 |
| loSin | output | DATA_W | Sine, signed Q1.15 |

## Verification
The assertions assume that `advance` and `phaseInc` are driven to known values whenever reset is low. They also assume reset stays high long enough to clear the output registers. The bench drives both inputs only away from the clock edge and holds reset for several cycles at the start and at each restart. The unit-circle magnitude check assumes the default 10-bit table, and the stimulus uses only that setting.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef struct packed {
    logic step;     // add the increment to the phase
    logic capture;  // register a new table read
  } nco_strobe_t;

  // Rounded, clamped sine sample for table index idx of depth entries.
  function automatic int sinEntry(input int idx, input int depth, input int dataW);
    real ang, x2, term, sum, scale, v;
    int  r, maxV;
    ang = 2.0 * 3.14159265358979323846 * idx / depth;
    if (ang > 3.14159265358979323846) ang = ang - 2.0 * 3.14159265358979323846;
    x2   = ang * ang;
    term = ang;
    sum  = ang;
    for (int k = 1; k < 14; k++) begin
      term = -term * x2 / ((2.0 * k) * (2.0 * k + 1.0));
      sum  = sum + term;
    end
    scale = 2.0 ** (dataW - 1);
    v     = sum * scale;
    if (v >= 0.0) r = $rtoi(v + 0.5);
    else          r = -$rtoi(-v + 0.5);
    maxV = (1 << (dataW - 1)) - 1;
    if (r > maxV) r = maxV;
    if (r < -maxV - 1) r = -maxV - 1;
    return r;
  endfunction

endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 advance,
  output nco_pkg::nco_strobe_t strb,
  output logic                 validOut
);
  always_comb begin
    strb.step    = advance;
    strb.capture = advance;
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= advance;
  end
endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom #(
  parameter int LUT_AW = 10,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rdEn,
  input  logic [LUT_AW-1:0]        addr,
  output logic signed [DATA_W-1:0] cosVal,
  output logic signed [DATA_W-1:0] sinVal
);
  localparam int DEPTH = 1 << LUT_AW;
  localparam logic [LUT_AW-1:0] QTR = LUT_AW'(DEPTH / 4);

  logic signed [DATA_W-1:0] tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    localparam int ENTRY = nco_pkg::sinEntry(g, DEPTH, DATA_W);
    assign tab[g] = DATA_W'(ENTRY);
  end

  logic [LUT_AW-1:0] cosAddr;
  assign cosAddr = addr + QTR;

  always_ff @(posedge clk) begin
    if (rst) begin
      cosVal <= '0;
      sinVal <= '0;
    end else if (rdEn) begin
      cosVal <= tab[cosAddr];
      sinVal <= tab[addr];
    end
  end
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 10,
  parameter int DATA_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  nco_pkg::nco_strobe_t     strb,
  input  logic [PHASE_W-1:0]       phaseInc,
  output logic signed [DATA_W-1:0] cosOut,
  output logic signed [DATA_W-1:0] sinOut
);
  logic [PHASE_W-1:0] phase;
  logic [LUT_AW-1:0]  tabAddr;

  assign tabAddr = phase[PHASE_W-1 -: LUT_AW];

  always_ff @(posedge clk) begin
    if (rst)            phase <= '0;
    else if (strb.step) phase <= phase + phaseInc;
  end

  nco_sincos_rom #(.LUT_AW(LUT_AW), .DATA_W(DATA_W)) u_rom (
    .clk    (clk),
    .rst    (rst),
    .rdEn   (strb.capture),
    .addr   (tabAddr),
    .cosVal (cosOut),
    .sinVal (sinOut)
  );
endmodule

// File: rtl/quad_nco.sv
module quad_nco #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 10,
  parameter int DATA_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     advance,
  input  logic [PHASE_W-1:0]       phaseInc,
  output logic                     loValid,
  output logic signed [DATA_W-1:0] loCos,
  output logic signed [DATA_W-1:0] loSin
);
  nco_pkg::nco_strobe_t strb;

  nco_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .strb     (strb),
    .validOut (loValid)
  );

  nco_datapath #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .phaseInc (phaseInc),
    .cosOut   (loCos),
    .sinOut   (loSin)
  );
endmodule

// File: rtl/quad_nco_chk.sv
module quad_nco_chk #(
  parameter int PHASE_W = 32,
  parameter int DATA_W  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     advance,
  input logic [PHASE_W-1:0]       phaseInc,
  input logic                     loValid,
  input logic signed [DATA_W-1:0] loCos,
  input logic signed [DATA_W-1:0] loSin
);
  longint magSq;
  assign magSq = longint'(loCos) * longint'(loCos) + longint'(loSin) * longint'(loSin);

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> loValid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> !loValid);

  // R7
  hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> ($stable(loCos) && $stable(loSin)));

  // R5
  unit_circle_chk: assert property (@(posedge clk) disable iff (rst)
    loValid |-> (magSq >= 64'd1069290000 && magSq <= 64'd1073807361));
endmodule

bind quad_nco quad_nco_chk #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .advance  (advance),
  .phaseInc (phaseInc),
  .loValid  (loValid),
  .loCos    (loCos),
  .loSin    (loSin)
);

// File: tb/quad_nco_bench.sv
module quad_nco_bench;
  localparam int PW = 32;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          advance = 1'b0;
  logic [PW-1:0] phaseInc = '0;
  logic          loValid;
  logic signed [15:0] loCos, loSin;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  quad_nco u_quad_nco (
    .clk(clk), .rst(rst), .advance(advance), .phaseInc(phaseInc),
    .loValid(loValid), .loCos(loCos), .loSin(loSin)
  );

  function automatic int refVal(input logic [PW-1:0] ph, input bit isCos);
    int  idx;
    real ang, v;
    int  r;
    idx = int'(ph >> (PW - AW));
    ang = 2.0 * 3.14159265358979323846 * idx / (1 << AW);
    v   = (isCos ? $cos(ang) : $sin(ang)) * 32768.0;
    if (v >= 0.0) r = $rtoi(v + 0.5);
    else          r = -$rtoi(-v + 0.5);
    if (r > 32767) r = 32767;
    return r;
  endfunction

  // behavioural reference, updated on every clock
  logic [PW-1:0] mPhase = '0;
  bit            expV = 0;
  int            expC = 0, expS = 0;
  always @(posedge clk) begin
    if (rst) begin
      mPhase <= '0; expV <= 0; expC <= 0; expS <= 0;
    end else begin
      expV <= advance;
      if (advance) begin
        expC   <= refVal(mPhase, 1);
        expS   <= refVal(mPhase, 0);
        mPhase <= mPhase + phaseInc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference (R2, R5, R9)
  bit autoOn = 0;
  always @(negedge clk) begin
    if (autoOn && !rst) begin
      chk(loValid == expV, "R2 valid", longint'(loValid), longint'(expV));
      chk((int'(loCos) - expC) <= 1 && (expC - int'(loCos)) <= 1, "R5/R9 cos", loCos, expC);
      chk((int'(loSin) - expS) <= 1 && (expS - int'(loSin)) <= 1, "R5/R9 sin", loSin, expS);
    end
  end

  task automatic tick(input logic a, input logic [PW-1:0] inc);
    advance  = a;
    phaseInc = inc;
    @(negedge clk);
  endtask

  task automatic restart();
    rst = 1'b1; advance = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic expPair(input int c, input int s, input string req);
    chk(loValid == 1'b1, req, longint'(loValid), 1);
    chk(loCos == 16'(c), req, loCos, c);
    chk(loSin == 16'(s), req, loSin, s);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic signed [15:0] hc, hs;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(loValid == 0 && loCos == 0 && loSin == 0, "R1 reset", loCos, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(loValid == 0 && loCos == 0 && loSin == 0, "R1 after reset", loCos, 0);
    autoOn = 1;

    // R6/R5/R9: quarter-turn steps
    tick(1, 32'h4000_0000); expPair(32767, 0, "R6 first output");
    tick(1, 32'h4000_0000); expPair(0, 32767, "R5 quarter");
    tick(1, 32'h4000_0000); expPair(-32768, 0, "R5 half");
    tick(1, 32'h4000_0000); expPair(0, -32768, "R5 three-quarter");

    // R7: hold with no advance
    hc = loCos; hs = loSin;
    tick(0, 32'h1234_5678);
    tick(0, 32'h0);
    tick(0, 32'hFFFF_FFFF);
    chk(loValid == 0, "R2 idle", longint'(loValid), 0);
    chk(loCos == hc && loSin == hs, "R7 hold", loSin, hs);
    tick(1, 32'h4000_0000); expPair(32767, 0, "R3/R7 phase kept while idle");

    // R8: negative increment
    restart();
    tick(1, 32'hC000_0000); expPair(32767, 0, "R8 first");
    tick(1, 32'hC000_0000); expPair(0, -32768, "R8 second");
    tick(1, 32'hC000_0000); expPair(-32768, 0, "R8 third");
    tick(1, 32'hC000_0000); expPair(0, 32767, "R8 fourth");

    // R3: wrap-around
    restart();
    tick(1, 32'h8000_0000); expPair(32767, 0, "R3 start");
    tick(1, 32'h8000_0000); expPair(-32768, 0, "R3 half");
    tick(1, 32'h8000_0000); expPair(32767, 0, "R3 wrapped");

    // R4: truncated low bits
    restart();
    tick(1, 32'h003F_FFFF); expPair(32767, 0, "R6 after restart");
    tick(1, 32'h003F_FFFF); expPair(32767, 0, "R4 truncation");
    tick(1, 32'h003F_FFFF);

    // R9/R2/R5: gapped advances with changing increments
    restart();
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(lfsr[0] | lfsr[3], {lfsr, lfsr[7:0], lfsr[15:8]});
    end
    tick(0, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule